// File: doc/BRIEF.md
# DMA channel control and status register bank

This block holds the control and status state that a 16-channel DMA controller shares with software. For each channel it keeps a freeze bit, a self-clearing reset request, a completion flag with its interrupt enable, an error flag and an error type. Two global bits turn on bus bursts toward the peripherals. The channel engines report events to the block as one-cycle pulses: a finished command, a terminated command or a bus fault. The block turns the flags into one interrupt line per channel.

Software uses a 32-bit memory-mapped port whose writes complete in a single cycle. Reads are combinational. Each register occupies a 16-byte slot with four write views. A plain write replaces the whole register. The three alias views set, clear or invert only the bits written as 1, so a driver can change a single channel without reading the register first. Both halves of each register are packed so that bit n always belongs to channel n.

Top module: `dma_chan_regs`

## Requirements
- R1: Slot offsets are 0x00 (control), 0x10 (completion), 0x20 (error) and 0x30 (channel control). Within a slot, offset +0x0 is the plain-write view and replaces the register. After reset every register reads 0. Reads at any view of a slot return the current register value.
- R2: A write to view +0x4 ORs the data into the register. Bits written 0 are unchanged.
- R3: A write to view +0x8 clears the bits written 1. Other bits are unchanged.
- R4: A write to view +0xC inverts the bits written 1. Other bits are unchanged.
- R5: Control bits 15:0 are the per-channel freeze bits and drive `chan_freeze`. Channel-control bits 15:0 are a second view of the same freeze bits, for both reads and writes.
- R6: A write that leaves 1 in channel-control bit 16+n, through the plain, set or toggle view, drives `chan_reset[n]` high for exactly the following cycle. Bits 31:16 of channel control always read 0.
- R7: A pulse on `evt_done[n]` sets completion bit n at the next edge. Completion bits 31:16 are the per-channel interrupt enables.
- R8: A pulse on `evt_term[n]` or `evt_buserr[n]` sets error bit n. Error bit 16+n becomes 0 for a termination and 1 for a bus fault. If both pulses arrive together, the bus fault wins.
- R9: When a hardware event and a software write that clears the same flag land in the same cycle, the flag ends up set.
- R10: `chan_irq[n]` is 1 exactly when completion bit n or error bit n is set and enable bit n is 1.
- R11: Control bit 28 drives `burst_en` and bit 29 drives `burst8_en`. Control bits 27:16, 30 and 31 read 0.
- R12: Offsets 0x40 and above, and addresses with either of the two low address bits set, read 0 and a write to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_done | input | 16 | Per-channel completion pulses |
| evt_term | input | 16 | Per-channel termination pulses |
| evt_buserr | input | 16 | Per-channel bus fault pulses |
| chan_irq | output | 16 | Per-channel interrupt lines |
| chan_freeze | output | 16 | Per-channel freeze controls |
| chan_reset | output | 16 | Per-channel one-cycle reset pulses |
| burst_en | output | 1 | Peripheral bus burst enable |
| burst8_en | output | 1 | Eight-beat burst enable |

## Verification
The hardest situation to create is a collision in a single cycle. One case is a software clear or toggle landing on a flag that an engine sets in the same cycle. Another is a termination and a bus fault hitting one channel together. Random stimulus produces these only occasionally, so directed cycles force each pairing. Around them runs a long stream of random aliased writes mixed with sparse random event pulses, and the bench compares every read and every output against a model built from the requirements.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] evt_done,
  input  logic [NCH-1:0] evt_term,
  input  logic [NCH-1:0] evt_buserr,
  output logic [NCH-1:0] chan_irq,
  output logic [NCH-1:0] chan_freeze,
  output logic [NCH-1:0] chan_reset,
  output logic           burst_en,
  output logic           burst8_en
);
  localparam int SW = AW - 4;
  localparam logic [SW-1:0] S_CTL = 0, S_CMP = 1, S_ERR = 2, S_CHC = 3;

  logic [NCH-1:0] frz, en, cmp, err, etyp, rst_q;
  logic bst, bst8;

  wire [SW-1:0] sel = bus_addr[AW-1:4];
  wire [1:0]    op  = bus_addr[3:2];
  wire aligned = (bus_addr[1:0] == 2'b00);
  wire wr_ctl = bus_wr && aligned && sel == S_CTL;
  wire wr_cmp = bus_wr && aligned && sel == S_CMP;
  wire wr_err = bus_wr && aligned && sel == S_ERR;
  wire wr_chc = bus_wr && aligned && sel == S_CHC;

  function automatic logic [31:0] alias_op(input logic [1:0] o, input logic [31:0] cur, input logic [31:0] w);
    case (o)
      2'd0:    return w;
      2'd1:    return cur | w;
      2'd2:    return cur & ~w;
      default: return cur ^ w;
    endcase
  endfunction

  wire [31:0] cur_ctl = {2'b00, bst8, bst, {(NCH-4){1'b0}}, frz};
  wire [31:0] cur_cmp = {en, cmp};
  wire [31:0] cur_err = {etyp, err};
  wire [31:0] cur_chc = {{NCH{1'b0}}, frz};

  wire [31:0] nxt_ctl = alias_op(op, cur_ctl, bus_wdata);
  wire [31:0] nxt_cmp = alias_op(op, cur_cmp, bus_wdata);
  wire [31:0] nxt_err = alias_op(op, cur_err, bus_wdata);
  wire [31:0] nxt_chc = alias_op(op, cur_chc, bus_wdata);

  wire [NCH-1:0] err_evt  = evt_term | evt_buserr;
  wire [NCH-1:0] err_base = wr_err ? nxt_err[NCH-1:0] : err;
  wire [NCH-1:0] typ_base = wr_err ? nxt_err[31:NCH] : etyp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz <= '0; en <= '0; cmp <= '0; err <= '0; etyp <= '0; rst_q <= '0;
      bst <= 1'b0; bst8 <= 1'b0;
    end else begin
      if (wr_ctl) begin
        frz  <= nxt_ctl[NCH-1:0];
        bst  <= nxt_ctl[28];
        bst8 <= nxt_ctl[29];
      end else if (wr_chc) begin
        frz  <= nxt_chc[NCH-1:0];
      end
      if (wr_cmp) en <= nxt_cmp[31:NCH];
      cmp   <= (wr_cmp ? nxt_cmp[NCH-1:0] : cmp) | evt_done;
      err   <= err_base | err_evt;
      etyp  <= (typ_base & ~err_evt) | evt_buserr;
      rst_q <= wr_chc ? nxt_chc[31:NCH] : '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        S_CTL:   bus_rdata = cur_ctl;
        S_CMP:   bus_rdata = cur_cmp;
        S_ERR:   bus_rdata = cur_err;
        S_CHC:   bus_rdata = cur_chc;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign chan_irq    = (cmp | err) & en;
  assign chan_freeze = frz;
  assign chan_reset  = rst_q;
  assign burst_en    = bst;
  assign burst8_en   = bst8;

  assert_reset_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_chc |=> (chan_reset == '0));

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done != '0) |=> ((cmp & $past(evt_done)) == $past(evt_done)));

  assert_buserr_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_buserr != '0) |=> ((err & etyp & $past(evt_buserr)) == $past(evt_buserr)));

  assert_term_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_term & ~evt_buserr) != '0) |=> ((etyp & $past(evt_term & ~evt_buserr)) == '0));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && evt_done == '0 && err_evt == '0) |=> ($stable(cmp) && $stable(err) && $stable(etyp)));

  assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(chan_freeze));
endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] evt_done = 0, evt_term = 0, evt_buserr = 0;
  logic [15:0] chan_irq, chan_freeze, chan_reset;
  logic burst_en, burst8_en;

  int checks = 0, errors = 0;
  logic [15:0] m_frz = 0, m_en = 0, m_cmp = 0, m_err = 0, m_typ = 0, m_rst = 0;
  logic m_b = 0, m_b8 = 0;

  dma_chan_regs u_dma_chan_regs (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a[7:4])
      4'd0: return {2'b00, m_b8, m_b, 12'h000, m_frz};
      4'd1: return {m_en, m_cmp};
      4'd2: return {m_typ, m_err};
      4'd3: return {16'h0000, m_frz};
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_alias(input logic [1:0] o, input logic [31:0] c, input logic [31:0] w);
    case (o)
      2'd0: return w;
      2'd1: return c | w;
      2'd2: return c & ~w;
      default: return c ^ w;
    endcase
  endfunction

  task automatic m_update(input logic wr, input logic [7:0] a, input logic [31:0] w,
                          input logic [15:0] d, input logic [15:0] t, input logic [15:0] b);
    logic [31:0] n;
    logic [15:0] eb, tb;
    n = m_alias(a[3:2], m_read(a), w);
    m_rst = 0;
    eb = m_err; tb = m_typ;
    if (wr && a[1:0] == 0) begin
      case (a[7:4])
        4'd0: begin m_frz = n[15:0]; m_b = n[28]; m_b8 = n[29]; end
        4'd1: begin m_en = n[31:16]; m_cmp = n[15:0]; end
        4'd2: begin eb = n[15:0]; tb = n[31:16]; end
        4'd3: begin m_frz = n[15:0]; m_rst = n[31:16]; end
        default: ;
      endcase
    end
    m_cmp = m_cmp | d;
    m_err = eb | t | b;
    m_typ = (tb & ~(t | b)) | b;
  endtask

  task automatic cyc(input string tag, input logic wr, input logic [7:0] a, input logic [31:0] w,
                     input logic [15:0] d, input logic [15:0] t, input logic [15:0] b);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = w;
    evt_done = d; evt_term = t; evt_buserr = b;
    #1 chk({tag, " R1 read"}, bus_rdata, m_read(a));
    @(posedge clk);
    m_update(wr, a, w, d, t, b);
    #1;
    chk({tag, " R10 irq"}, {16'h0, chan_irq}, {16'h0, (m_cmp | m_err) & m_en});
    chk({tag, " R5 freeze"}, {16'h0, chan_freeze}, {16'h0, m_frz});
    chk({tag, " R6 reset pulse"}, {16'h0, chan_reset}, {16'h0, m_rst});
    chk({tag, " R11 burst"}, {30'h0, burst8_en, burst_en}, {30'h0, m_b8, m_b});
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 0; bus_addr = a; evt_done = 0; evt_term = 0; evt_buserr = 0;
    #1 chk(tag, bus_rdata, exp);
    @(posedge clk);
    m_update(0, a, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 reset irq", {16'h0, chan_irq}, 32'h0);
    chk("R1 reset freeze", {16'h0, chan_freeze}, 32'h0);
    for (int s = 0; s < 4; s++) rd("R1 reset read", 8'(s * 16), 32'h0);

    cyc("R1 plain", 1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R11 reserved bits", 8'h00, 32'h3000_FFFF);
    cyc("R3 clear", 1, 8'h08, 32'h1000_00F0, 0, 0, 0);
    cyc("R2 set", 1, 8'h14, 32'h0003_0000, 0, 0, 0);
    cyc("R4 toggle", 1, 8'h3C, 32'h0000_0101, 0, 0, 0);
    cyc("R6 request", 1, 8'h34, 32'h8001_0000, 0, 0, 0);
    rd("R6 readback", 8'h30, {16'h0, m_frz});
    cyc("R7 done", 0, 8'h10, 0, 16'h0001, 0, 0);
    cyc("R9 clear vs done", 1, 8'h18, 32'h0000_0001, 16'h0001, 0, 0);
    rd("R9 flag kept", 8'h10, 32'h0003_0001);
    cyc("R8 both", 0, 8'h20, 0, 0, 16'h0002, 16'h0002);
    rd("R8 bus fault wins", 8'h20, 32'h0002_0002);
    cyc("R8 term", 0, 8'h20, 0, 0, 16'h0004, 0);
    cyc("R9 toggle vs term", 1, 8'h2C, 32'h0000_0004, 0, 16'h0004, 0);
    rd("R8 term type", 8'h20, 32'h0002_0006);
    cyc("R12 unmapped", 1, 8'h40, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R12 misaligned", 1, 8'h11, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R12 read", 8'h44, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      logic [7:0] a;
      s = 4'($urandom % 6);
      if (s == 5) s = 4'hF;
      a = {s, 2'($urandom), (($urandom % 16) == 0) ? 2'($urandom) : 2'b00};
      cyc("rand", ($urandom % 3) != 0, a, $urandom,
          16'($urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom & $urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule